// File: doc/BRIEF.md
# Shadow Instruction Remapper

This combinational block produces the shadow copy of an instruction for fault detection by duplicated execution. It takes the already-decoded fields of a 32-bit instruction, one type flag for each supported class, and the original instruction word. From these it builds a rewritten word that the shadow stream runs. The rewritten word uses only the upper half of the register file. For loads and stores it also uses a separate region of memory, so the duplicate cannot change state that the original instruction relies on.

Four classes are supported: loads, stores, register-register ALU operations and register-immediate ALU operations. Register operands are remapped in every class. The address offset is remapped only in the two memory classes. When several type flags are set together, a fixed priority decides which rewritten word is driven out. When no flag is set, the original word passes through unchanged.

Top module: `dup_instr_remap`

## Requirements
- R1: A register operand (rd, rs1 or rs2) equal to 0 is copied to the output unchanged.
- R2: A nonzero register operand is output with bit 4 set to 1 and bits 3:0 kept.
- R3: For a load, the 12-bit offset in output bits 31:20 becomes binary 01 followed by offset bits 9:0.
- R4: For a store, the 12-bit offset {hi7, lo5} becomes binary 01 followed by offset bits 9:0. The upper 7 bits go to output bits 31:25 and the lower 5 bits go to output bits 11:7. The rd input is not used.
- R5: For ALU classes, the immediate (register-immediate class, bits 31:20) and the funct7 field (register-register class, bits 31:25) are copied unchanged.
- R6: Output field layout per class, with ':' marking bit ranges:
  - register-register: funct7 31:25, rs2 24:20, rs1 19:15, funct3 14:12, rd 11:7, opcode 6:0.
  - register-immediate and load: imm 31:20, rs1 19:15, funct3 14:12, rd 11:7, opcode 6:0.
  - store: offset-high 31:25, rs2 24:20, rs1 19:15, funct3 14:12, offset-low 11:7, opcode 6:0.
- R7: When several type flags are set, the class that drives the output is chosen in this order: load, then store, then register-register, then register-immediate.
- R8: When no type flag is set, the output equals the pass-through instruction input.
- R9: In every class, opcode (bits 6:0) and funct3 (bits 14:12) are copied unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Decoded opcode field |
| rd | input | 5 | Destination register field |
| funct3 | input | 3 | Minor function field |
| rs1 | input | 5 | First source register field |
| rs2 | input | 5 | Second source register field |
| funct7 | input | 7 | Major function field |
| imm12 | input | 12 | Immediate / load offset |
| st_off_hi | input | 7 | Store offset bits 11:5 |
| st_off_lo | input | 5 | Store offset bits 4:0 |
| is_load | input | 1 | Instruction is a load |
| is_store | input | 1 | Instruction is a store |
| is_alu_rr | input | 1 | Instruction is register-register ALU |
| is_alu_ri | input | 1 | Instruction is register-immediate ALU |
| pass_instr | input | 32 | Original word, used when no flag is set |
| remap_instr | output | 32 | Remapped shadow instruction |

## Verification
The hardest situation to reach is the one where several type flags are set at once. A correct decoder never produces that, so the priority order only shows when flags are forced together. The table therefore includes rows with two, three and all four flags raised over the same field values. It also includes rows where fields that the winning class does not use carry nonzero values, such as the rd port on a store and funct7/rs2 on a register-immediate instruction. A stray field that leaks into the output then becomes visible.

// File: rtl/dup_remap_pkg.sv
package dup_remap_pkg;

    localparam int INSN_W  = 32;
    localparam int REG_W   = 5;
    localparam int OPC_W   = 7;
    localparam int F3_W    = 3;
    localparam int F7_W    = 7;
    localparam int IMM_W   = 12;
    localparam int SLO_W   = 5;
    localparam int SHI_W   = IMM_W - SLO_W;
    localparam int N_TYPES = 4;
    localparam int N_REGS  = 3;

    // Type indices; lower index has higher priority.
    localparam int IDX_LOAD  = 0;
    localparam int IDX_STORE = 1;
    localparam int IDX_RR    = 2;
    localparam int IDX_RI    = 3;

    // Classes whose address offset is moved into the shadow region.
    localparam logic [N_TYPES-1:0] MEM_TYPES = 4'b0011;

    // Register operand slots.
    localparam int SLOT_RD  = 0;
    localparam int SLOT_RS1 = 1;
    localparam int SLOT_RS2 = 2;

    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [IMM_W-1:0]  off_t;
    typedef logic [INSN_W-1:0] insn_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        reg_idx_t         rd;
        logic [F3_W-1:0]  f3;
        reg_idx_t         rs1;
        reg_idx_t         rs2;
        logic [F7_W-1:0]  f7;
        off_t             imm;
        off_t             soff;
    } fields_t;

    // Zero stays zero; every other index is moved into the upper half.
    function automatic reg_idx_t shadow_reg(input reg_idx_t r);
        return (r == '0) ? r : {1'b1, r[REG_W-2:0]};
    endfunction

    // Offset moved into the shadow memory region.
    function automatic off_t shadow_off(input off_t o);
        return {2'b01, o[IMM_W-3:0]};
    endfunction

endpackage

// File: rtl/dup_reg_remap.sv
module dup_reg_remap
    import dup_remap_pkg::*;
(
    input  reg_idx_t orig,
    output reg_idx_t shadow
);
    always_comb shadow = shadow_reg(orig);

    always_comb begin
        if (orig == '0)
            AST_ZERO_REG_KEPT: assert (shadow == '0); // R1
        else
            AST_REG_UPPER_HALF: assert (shadow[REG_W-1] && shadow[REG_W-2:0] == orig[REG_W-2:0]); // R2
    end
endmodule

// File: rtl/dup_off_remap.sv
module dup_off_remap
    import dup_remap_pkg::*;
(
    input  off_t orig,
    output off_t shadow
);
    always_comb shadow = shadow_off(orig);
endmodule

// File: rtl/dup_word_build.sv
module dup_word_build
    import dup_remap_pkg::*;
(
    input  fields_t                       raw,
    input  reg_idx_t [N_REGS-1:0]         regs_new,
    input  off_t                          imm_new,
    input  off_t                          soff_new,
    output logic [N_TYPES-1:0][INSN_W-1:0] words
);
    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
        off_t ioff;
        off_t soff;
        if (MEM_TYPES[t]) begin : g_mem
            assign ioff = imm_new;
            assign soff = soff_new;
        end else begin : g_alu
            assign ioff = raw.imm;
            assign soff = raw.soff;
        end

        if (t == IDX_RR) begin : g_rr
            assign words[t] = {raw.f7, regs_new[SLOT_RS2], regs_new[SLOT_RS1],
                               raw.f3, regs_new[SLOT_RD], raw.opc};
        end else if (t == IDX_STORE) begin : g_st
            assign words[t] = {soff[IMM_W-1:SLO_W], regs_new[SLOT_RS2], regs_new[SLOT_RS1],
                               raw.f3, soff[SLO_W-1:0], raw.opc};
        end else begin : g_imm
            assign words[t] = {ioff, regs_new[SLOT_RS1], raw.f3,
                               regs_new[SLOT_RD], raw.opc};
        end
    end
endmodule

// File: rtl/dup_prio_sel.sv
module dup_prio_sel #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] cand,
    input  logic [W-1:0]        fallback,
    output logic [W-1:0]        out
);
    always_comb begin
        out = fallback;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) out = cand[i];
        end
    end
endmodule

// File: rtl/dup_instr_remap.sv
module dup_instr_remap
    import dup_remap_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [REG_W-1:0]  rd,
    input  logic [F3_W-1:0]   funct3,
    input  logic [REG_W-1:0]  rs1,
    input  logic [REG_W-1:0]  rs2,
    input  logic [F7_W-1:0]   funct7,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [SHI_W-1:0]  st_off_hi,
    input  logic [SLO_W-1:0]  st_off_lo,
    input  logic              is_load,
    input  logic              is_store,
    input  logic              is_alu_rr,
    input  logic              is_alu_ri,
    input  logic [INSN_W-1:0] pass_instr,
    output logic [INSN_W-1:0] remap_instr
);
    fields_t                        raw;
    reg_idx_t [N_REGS-1:0]          regs_orig;
    reg_idx_t [N_REGS-1:0]          regs_new;
    off_t                           imm_new;
    off_t                           soff_new;
    logic [N_TYPES-1:0][INSN_W-1:0] words;
    logic [N_TYPES-1:0]             flags;

    always_comb begin
        raw.opc  = opcode;
        raw.rd   = rd;
        raw.f3   = funct3;
        raw.rs1  = rs1;
        raw.rs2  = rs2;
        raw.f7   = funct7;
        raw.imm  = imm12;
        raw.soff = {st_off_hi, st_off_lo};
        regs_orig[SLOT_RD]  = rd;
        regs_orig[SLOT_RS1] = rs1;
        regs_orig[SLOT_RS2] = rs2;
        flags[IDX_LOAD]  = is_load;
        flags[IDX_STORE] = is_store;
        flags[IDX_RR]    = is_alu_rr;
        flags[IDX_RI]    = is_alu_ri;
    end

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        dup_reg_remap u_reg (.orig(regs_orig[r]), .shadow(regs_new[r]));
    end

    dup_off_remap u_imm  (.orig(raw.imm),  .shadow(imm_new));
    dup_off_remap u_soff (.orig(raw.soff), .shadow(soff_new));

    dup_word_build u_build (
        .raw      (raw),
        .regs_new (regs_new),
        .imm_new  (imm_new),
        .soff_new (soff_new),
        .words    (words)
    );

    dup_prio_sel #(.N(N_TYPES), .W(INSN_W)) u_sel (
        .sel      (flags),
        .cand     (words),
        .fallback (pass_instr),
        .out      (remap_instr)
    );

    // Port-level checks against the field layout.
    logic store_wins;
    logic rr_wins;
    always_comb begin
        store_wins = is_store && !is_load;
        rr_wins    = is_alu_rr && !is_load && !is_store;
        if (!(is_load || is_store || is_alu_rr || is_alu_ri))
            AST_PASS_THROUGH: assert (remap_instr == pass_instr); // R8
        if (is_load)
            AST_LOAD_OFFSET: assert (remap_instr[31:30] == 2'b01 && remap_instr[29:20] == imm12[9:0]); // R3
        if (store_wins)
            AST_STORE_OFFSET: assert (remap_instr[31:30] == 2'b01 && remap_instr[29:25] == st_off_hi[4:0] && remap_instr[11:7] == st_off_lo); // R4
        if (rr_wins)
            AST_RR_FUNCT_KEPT: assert (remap_instr[31:25] == funct7); // R5
        if (is_load || is_store || is_alu_rr || is_alu_ri)
            AST_OPC_F3_KEPT: assert (remap_instr[6:0] == opcode && remap_instr[14:12] == funct3); // R9
        if ((is_load || is_store || is_alu_rr || is_alu_ri) && rs1 != '0)
            AST_RS1_UPPER: assert (remap_instr[19]); // R2
        if (!store_wins && (is_load || is_alu_rr || is_alu_ri) && rd == '0)
            AST_RD_ZERO_KEPT: assert (remap_instr[11:7] == '0); // R1
    end
endmodule

// File: tb/sim_dup_instr_remap.sv
module sim_dup_instr_remap;

    logic        clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [6:0]  opcode;
    logic [4:0]  rd;
    logic [2:0]  funct3;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [6:0]  funct7;
    logic [11:0] imm12;
    logic [6:0]  st_off_hi;
    logic [4:0]  st_off_lo;
    logic        is_load, is_store, is_alu_rr, is_alu_ri;
    logic [31:0] pass_instr;
    logic [31:0] remap_instr;

    dup_instr_remap u0 (
        .opcode(opcode), .rd(rd), .funct3(funct3), .rs1(rs1), .rs2(rs2),
        .funct7(funct7), .imm12(imm12), .st_off_hi(st_off_hi), .st_off_lo(st_off_lo),
        .is_load(is_load), .is_store(is_store), .is_alu_rr(is_alu_rr), .is_alu_ri(is_alu_ri),
        .pass_instr(pass_instr), .remap_instr(remap_instr)
    );

    // fl bits: [3]=reg-imm, [2]=reg-reg, [1]=store, [0]=load
    typedef struct packed {
        logic [3:0]  fl;
        logic [6:0]  op;
        logic [4:0]  rd;
        logic [2:0]  f3;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [6:0]  f7;
        logic [11:0] imm;
        logic [6:0]  shi;
        logic [4:0]  slo;
        logic [31:0] pass;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        // 0: reg-reg, rs1 zero, rd/rs2 remapped
        '{4'b0100, 7'h33, 5'd7, 3'd0, 5'd0, 5'd3, 7'h20, 12'h155, 7'h11, 5'd9, 32'h1,
          {7'h20, 5'd19, 5'd0, 3'd0, 5'd23, 7'h33}},
        // 1: reg-imm, immediate kept, rd zero
        '{4'b1000, 7'h13, 5'd0, 3'd4, 5'd31, 5'd6, 7'h55, 12'hFFF, 7'h22, 5'd3, 32'h2,
          {12'hFFF, 5'd31, 3'd4, 5'd0, 7'h13}},
        // 2: load, offset remapped
        '{4'b0001, 7'h03, 5'd16, 3'd2, 5'd2, 5'd9, 7'h7F, 12'hABC, 7'h00, 5'd0, 32'h3,
          {12'h6BC, 5'd18, 3'd2, 5'd16, 7'h03}},
        // 3: store, all-ones offset, rd port ignored
        '{4'b0010, 7'h23, 5'd12, 3'd2, 5'd0, 5'd1, 7'h3C, 12'h0F0, 7'h7F, 5'h1F, 32'h4,
          {7'h3F, 5'd17, 5'd0, 3'd2, 5'h1F, 7'h23}},
        // 4: no flags, pass-through
        '{4'b0000, 7'h33, 5'd5, 3'd1, 5'd5, 5'd5, 7'h01, 12'h123, 7'h01, 5'd1, 32'hDEADBEEF,
          32'hDEADBEEF},
        // 5: all flags, load wins
        '{4'b1111, 7'h03, 5'd16, 3'd2, 5'd2, 5'd9, 7'h7F, 12'hABC, 7'h55, 5'd4, 32'h5,
          {12'h6BC, 5'd18, 3'd2, 5'd16, 7'h03}},
        // 6: store+rr+ri, store wins
        '{4'b1110, 7'h23, 5'd12, 3'd2, 5'd0, 5'd1, 7'h3C, 12'h0F0, 7'h7F, 5'h1F, 32'h6,
          {7'h3F, 5'd17, 5'd0, 3'd2, 5'h1F, 7'h23}},
        // 7: rr+ri, rr wins
        '{4'b1100, 7'h33, 5'd7, 3'd0, 5'd0, 5'd3, 7'h20, 12'h155, 7'h11, 5'd9, 32'h7,
          {7'h20, 5'd19, 5'd0, 3'd0, 5'd23, 7'h33}},
        // 8: reg-imm, zero immediate, rs1 zero, rd 15
        '{4'b1000, 7'h13, 5'd15, 3'd0, 5'd0, 5'd31, 7'h7F, 12'h000, 7'h7F, 5'd31, 32'h8,
          {12'h000, 5'd0, 3'd0, 5'd31, 7'h13}},
        // 9: store, zero offset
        '{4'b0010, 7'h23, 5'd0, 3'd0, 5'd15, 5'd0, 7'h00, 12'hFFF, 7'h00, 5'd0, 32'h9,
          {7'h20, 5'd0, 5'd31, 3'd0, 5'd0, 7'h23}},
        // 10: load, zero offset, zero registers
        '{4'b0001, 7'h03, 5'd0, 3'd7, 5'd0, 5'd0, 7'h00, 12'h000, 7'h00, 5'd0, 32'hA,
          {12'h400, 5'd0, 3'd7, 5'd0, 7'h03}},
        // 11: no flags, zero pass word
        '{4'b0000, 7'h7F, 5'd31, 3'd7, 5'd31, 5'd31, 7'h7F, 12'hFFF, 7'h7F, 5'd31, 32'h0,
          32'h0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 8:    return "R1/R2/R6";
            1:       return "R5/R1";
            2, 10:   return "R3/R2";
            3, 9:    return "R4/R6";
            4, 11:   return "R8";
            5, 6, 7: return "R7";
            default: return "R9";
        endcase
    endfunction

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(posedge clk);
        {is_alu_ri, is_alu_rr, is_store, is_load} = v.fl;
        opcode = v.op; rd = v.rd; funct3 = v.f3; rs1 = v.rs1; rs2 = v.rs2;
        funct7 = v.f7; imm12 = v.imm; st_off_hi = v.shi; st_off_lo = v.slo;
        pass_instr = v.pass;
        @(negedge clk);
    endtask

    initial begin
        vec_t v;
        v = '0;
        // Idle state: all inputs zero, no flags -> zero word
        apply(v);
        chk("R8 idle", remap_instr, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            chk(tag_of(i), remap_instr, TBL[i].exp);
        end

        // R2 corner: rd already in upper half, rs1 all ones, rs2 zero (R1)
        v = '0;
        v.fl = 4'b0100; v.op = 7'h33; v.rd = 5'd16; v.rs1 = 5'd31; v.rs2 = 5'd0;
        v.f3 = 3'd1; v.f7 = 7'h01;
        apply(v);
        chk("R2 upper-half regs", remap_instr, {7'h01, 5'd0, 5'd31, 3'd1, 5'd16, 7'h33});

        // R6: reg-imm ignores funct7/rs2 ports
        v = '0;
        v.fl = 4'b1000; v.op = 7'h13; v.f7 = 7'h7F; v.rs2 = 5'd31; v.shi = 7'h7F; v.slo = 5'd31;
        apply(v);
        chk("R6 reg-imm layout", remap_instr, 32'h0000_0013);

        // R4: store ignores rd port
        v = '0;
        v.fl = 4'b0010; v.op = 7'h23; v.rd = 5'd31;
        apply(v);
        chk("R4 store rd ignored", remap_instr, {7'h20, 5'd0, 5'd0, 3'd0, 5'd0, 7'h23});

        // R9: opcode and funct3 copied in each class
        for (int t = 0; t < 4; t++) begin
            v = '0;
            v.fl = 4'(1 << t); v.op = 7'h5A; v.f3 = 3'd5;
            apply(v);
            chk("R9 opcode", {25'h0, remap_instr[6:0]}, 32'h5A);
            chk("R9 funct3", {29'h0, remap_instr[14:12]}, 32'h5);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule